// File: doc/BRIEF.md
# Carry-Forwarding Rotate and Arithmetic Execute Stage

This block is the execute stage of a small pipelined datapath. Each cycle it may accept one instruction: a two-bit opcode, two operand words and a valid bit. It performs unsigned add, unsigned subtract, rotate left through carry, and rotate right through carry. The stage registers a result word and the carry that the instruction produced. An architectural carry flag register is written from that stage output one cycle later.

A rotate needs the carry left by the instruction before it. When that instruction entered on the previous cycle, its carry is not yet in the flag register. A bypass path returns the carry at the stage output to the stage input, so the rotate uses the fresh value. The pipeline never stalls for this: one valid instruction can enter every cycle. The results match those of a machine that runs the same instructions one at a time.

Top module: `cfr_exec_stage`

## Requirements
- R1: While reset is asserted and after it is released, `res_q`, `carry_q`, `res_valid_q` and `flag_q` are all 0 until the first valid instruction completes.
- R2: Opcode 2'b00 (add) gives `res_q` = (a + b) mod 2^W and `carry_q` = bit W of the full sum. The incoming carry is not used.
- R3: Opcode 2'b01 (subtract) gives `res_q` = (a - b) mod 2^W and `carry_q` = 1 exactly when a < b as unsigned numbers (borrow).
- R4: Opcode 2'b10 (rotate left through carry) gives `res_q` = {a[W-2:0], cin} and `carry_q` = a[W-1]. Operand b is ignored.
- R5: Opcode 2'b11 (rotate right through carry) gives `res_q` = {cin, a[W-1:1]} and `carry_q` = a[0]. Operand b is ignored.
- R6: The carry-in `cin` of an instruction comes from one of two places. If a valid instruction was accepted on the immediately preceding cycle, it is that instruction's `carry_q`. Otherwise it is `flag_q`. Either way it equals the carry left by the last earlier valid instruction, or 0 if there was none.
- R7: An instruction presented with `in_valid` high before a clock edge has its `res_q`, `carry_q` and `res_valid_q` = 1 visible right after that edge. Back-to-back valid instructions complete one per cycle with no stall.
- R8: `flag_q` takes the value of `carry_q` at the clock edge after a valid result appears. It therefore lags the stage output by exactly one instruction.
- R9: A cycle with `in_valid` low is a bubble. It drives `res_valid_q` to 0, leaves `res_q` and `carry_q` unchanged, does not write `flag_q`, and does not arm the bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 2 | Opcode: 00 add, 01 subtract, 10 rotate left, 11 rotate right |
| in_a | input | W | First operand (rotated operand) |
| in_b | input | W | Second operand for add and subtract |
| res_q | output | W | Stage result word |
| carry_q | output | 1 | Carry produced by the instruction at the stage output |
| res_valid_q | output | 1 | Stage output holds a valid instruction result |
| flag_q | output | 1 | Architectural carry flag |

## Verification
The result, carry and valid bit of an instruction are due one clock edge after it is presented. The architectural flag catches up one edge later still. The bench drives inputs on falling edges and checks outputs on the next falling edge. At that point the flag must equal the sequential model's carry as it stood before the instruction just checked. The directed sequences place a rotate directly after an add or subtract that overflows or borrows, so the bypassed carry and the stale flag differ. They also separate such pairs with bubbles, so the carry must come from the flag register instead.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

    typedef enum logic [1:0] {
        OPC_ADD = 2'b00,
        OPC_SUB = 2'b01,
        OPC_RLC = 2'b10,
        OPC_RRC = 2'b11
    } cfr_opc_e;

    function automatic logic opc_is_rotate(input cfr_opc_e opc);
        return (opc == OPC_RLC) || (opc == OPC_RRC);
    endfunction

endpackage

// File: rtl/cfr_arith.sv
module cfr_arith #(
    parameter int W = 8
) (
    input  logic         is_sub,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] sum,
    output logic         cy
);
    localparam int XW = W + 1;

    logic [XW-1:0] wide;

    always_comb begin
        if (is_sub) begin
            wide = {1'b0, opa} - {1'b0, opb};
        end else begin
            wide = {1'b0, opa} + {1'b0, opb};
        end
        sum = wide[W-1:0];
        cy  = wide[XW-1];
    end
endmodule

// File: rtl/cfr_rotate.sv
module cfr_rotate #(
    parameter int W    = 8,
    parameter bit LEFT = 1'b1
) (
    input  logic [W-1:0] opa,
    input  logic         cin,
    output logic [W-1:0] rot,
    output logic         cy
);
    localparam int MSB = W - 1;

    generate
        if (LEFT) begin : g_left
            assign rot[0] = cin;
            for (genvar i = 1; i < W; i++) begin : g_bit
                assign rot[i] = opa[i-1];
            end
            assign cy = opa[MSB];
        end else begin : g_right
            assign rot[MSB] = cin;
            for (genvar i = 0; i < MSB; i++) begin : g_bit
                assign rot[i] = opa[i+1];
            end
            assign cy = opa[0];
        end
    endgenerate
endmodule

// File: rtl/cfr_fwd_sel.sv
module cfr_fwd_sel (
    input  logic prev_vld,
    input  logic prev_cy,
    input  logic arch_flag,
    output logic cin
);
    always_comb begin
        cin = prev_vld ? prev_cy : arch_flag;
    end
endmodule

// File: rtl/cfr_exec_stage.sv
module cfr_exec_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   in_op,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] res_q,
    output logic         carry_q,
    output logic         res_valid_q,
    output logic         flag_q
);
    import cfr_pkg::*;

    typedef struct packed {
        logic [W-1:0] res;
        logic         cy;
        logic         vld;
        logic         flag;
    } stage_t;

    stage_t   st_d, st_q;
    cfr_opc_e opc;
    logic     cin_w;
    logic [W-1:0] ar_res, rl_res, rr_res;
    logic         ar_cy, rl_cy, rr_cy;

    assign opc = cfr_opc_e'(in_op);

    cfr_fwd_sel u_fwd (
        .prev_vld  (st_q.vld),
        .prev_cy   (st_q.cy),
        .arch_flag (st_q.flag),
        .cin       (cin_w)
    );

    cfr_arith #(.W(W)) u_arith (
        .is_sub (opc == OPC_SUB),
        .opa    (in_a),
        .opb    (in_b),
        .sum    (ar_res),
        .cy     (ar_cy)
    );

    cfr_rotate #(.W(W), .LEFT(1'b1)) u_rol (
        .opa (in_a),
        .cin (cin_w),
        .rot (rl_res),
        .cy  (rl_cy)
    );

    cfr_rotate #(.W(W), .LEFT(1'b0)) u_ror (
        .opa (in_a),
        .cin (cin_w),
        .rot (rr_res),
        .cy  (rr_cy)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (st_q.vld) begin
            st_d.flag = st_q.cy;
        end
        if (in_valid) begin
            if (!opc_is_rotate(opc)) begin
                st_d.res = ar_res;
                st_d.cy  = ar_cy;
            end else if (opc == OPC_RLC) begin
                st_d.res = rl_res;
                st_d.cy  = rl_cy;
            end else begin
                st_d.res = rr_res;
                st_d.cy  = rr_cy;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q       = st_q.res;
    assign carry_q     = st_q.cy;
    assign res_valid_q = st_q.vld;
    assign flag_q      = st_q.flag;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid_q); // R7
    AST_FLAG_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_q |=> (flag_q == $past(carry_q))); // R8
    AST_BUBBLE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_q |=> $stable(flag_q)); // R9
    AST_BUBBLE_KEEPS_RES: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_q) && $stable(carry_q) && !res_valid_q)); // R9
    AST_RLC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b10) |=> (carry_q == $past(in_a[W-1]))); // R4
    AST_RRC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b11) |=> (carry_q == $past(in_a[0]))); // R5
    AST_FWD_CIN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b10 && res_valid_q) |=> (res_q[0] == $past(carry_q))); // R6
endmodule

// File: tb/tb_cfr_exec_stage.sv
module tb_cfr_exec_stage;
    localparam int W = 8;
    localparam int NRAND = 3000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   in_op = 2'b00;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic [W-1:0] res_q;
    logic         carry_q;
    logic         res_valid_q;
    logic         flag_q;

    int n_chk = 0;
    int n_fail = 0;

    logic         m_c = 1'b0;
    logic [W-1:0] m_res = '0;
    logic         m_cy = 1'b0;

    always #5 clk = ~clk;

    cfr_exec_stage #(.W(W)) dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_op (in_op),
        .in_a (in_a), .in_b (in_b), .res_q (res_q), .carry_q (carry_q),
        .res_valid_q (res_valid_q), .flag_q (flag_q)
    );

    function automatic logic [W:0] model(input logic [1:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic c);
        logic [W:0] r;
        case (op)
            2'b00: r = {1'b0, a} + {1'b0, b};
            2'b01: begin
                r[W-1:0] = a - b;
                r[W] = (a < b);
            end
            2'b10: r = {a[W-1], a[W-2:0], c};
            default: r = {a[0], c, a[W-1:1]};
        endcase
        return r;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] op,
                        input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] r;
        logic flag_exp;
        string rq;
        in_valid = v; in_op = op; in_a = a; in_b = b;
        flag_exp = m_c;
        if (v) begin
            r = model(op, a, b, m_c);
            m_res = r[W-1:0];
            m_cy = r[W];
            m_c = r[W];
        end
        @(negedge clk);
        case (op)
            2'b00: rq = "R2";
            2'b01: rq = "R3";
            2'b10: rq = "R4/R6";
            default: rq = "R5/R6";
        endcase
        if (!v) rq = "R9";
        chk({rq, " res"}, res_q, m_res);
        chk({rq, " carry"}, W'(carry_q), W'(m_cy));
        chk("R7 valid", W'(res_valid_q), W'(v));
        chk("R8 flag", W'(flag_q), W'(flag_exp));
    endtask

    initial begin
        #(10 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        chk("R1 res", res_q, '0);
        chk("R1 flags", W'({carry_q, res_valid_q, flag_q}), '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", W'({carry_q, res_valid_q, flag_q}), '0);
        // R6: add overflow then rotate left, fresh carry forwarded
        step(1'b1, 2'b00, 8'hFF, 8'h01);
        step(1'b1, 2'b10, 8'h00, 8'hAA);
        // R3 borrow then rotate right, back to back
        step(1'b1, 2'b01, 8'h00, 8'h01);
        step(1'b1, 2'b11, 8'h02, 8'h00);
        // R9 bubble between arith and rotate: carry via flag register
        step(1'b1, 2'b00, 8'h80, 8'h80);
        step(1'b0, 2'b10, 8'h55, 8'h00);
        step(1'b0, 2'b01, 8'h00, 8'hFF);
        step(1'b1, 2'b10, 8'h40, 8'h00);
        // R4 R5 chained rotates, b ignored
        step(1'b1, 2'b10, 8'h81, 8'hFF);
        step(1'b1, 2'b11, 8'h01, 8'h3C);
        step(1'b1, 2'b11, 8'h00, 8'h00);
        step(1'b1, 2'b01, 8'h10, 8'h10);
        step(1'b1, 2'b10, 8'hFF, 8'h00);
        for (int i = 0; i < NRAND; i++) begin
            step(($urandom % 5) != 0, 2'($urandom), W'($urandom), W'($urandom));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule